// File: doc/BRIEF.md
# Host Buffer Access Port

This block gives a microprocessor byte-wide access to a large shared buffer memory that other agents also use. The host sees a small register window. Some of its registers hold a buffer address pointer, which is loaded one byte at a time. Two access registers move data between the host and the buffer location the pointer selects. One of them leaves the pointer unchanged. The other advances the pointer by one after each transfer. A data latch register keeps a copy of the last byte fetched from the buffer. On the memory side the block raises a request and waits for a grant. For a read it then waits for a data-valid strobe, so the memory may take any number of cycles.

The input `no_wait_mode` selects one of two host-bus styles.

- **Waitable mode:** the access starts on the leading edge of the host strobe. `rdy` holds the bus cycle until the buffer transfer has finished.
- **Non-waitable mode:** the access starts on the trailing edge of the strobe, and `rdy` is a status that is always visible. A host read of an access register returns the byte held from before and launches a fetch. The host polls `rdy` or `busy`. It then collects the fetched byte from the data latch, or from the access register. Reading the access register also starts the next fetch.

Register window (`addr`) for the default parameters:

| addr | Register |
|------|----------|
| 0 | pointer bits 7:0 |
| 1 | pointer bits 15:8 |
| 2 | pointer bits 19:16, in data bits 3:0 |
| 3 | plain access |
| 4 | auto-increment access |
| 5 | data latch (read only) |

Any other address reads 0.

The sequencer has four states:

- **IDLE:** no access is in progress.
- **REQ:** `mem_req` is high, waiting for `mem_gnt`.
- **RDWAIT:** a read has been granted and is waiting for `mem_rvalid`.
- **DONE:** a one-cycle completion state in which the pointer may step.

Its transitions are:

- IDLE→REQ on an accepted access trigger.
- REQ→DONE on a grant for a write.
- REQ→RDWAIT on a grant for a read.
- RDWAIT→DONE on `mem_rvalid`.
- DONE→IDLE always.

Top module: `hbuf_port`

## Requirements
- R1: After reset, `rdy`=1, `busy`=0, `mem_req`=0, all pointer bytes read 0, and the data latch (addr 5) reads 0.
- R2: Writing addr 0, 1 or 2 loads the matching pointer byte (byte 2 keeps only data bits 3:0). Reading those addresses returns the pointer, with unused upper bits as 0.
- R3: In waitable mode, the leading edge of a read or write strobe on addr 3 or 4 starts the access. `rdy` is 0 from that cycle until the transfer completes, then returns to 1. A read returns the buffer byte at the pointer. A write stores `wdata` at the pointer.
- R4: In waitable mode `rdy` is 1 whenever `cs` is 0, even while an access is in progress.
- R5: In non-waitable mode the access starts on the trailing edge of the strobe, the write byte is the one latched during the strobe, and `rdy` equals `!busy` regardless of `cs`.
- R6: In non-waitable mode, a read of addr 3 or 4 returns the access register's earlier contents and launches a fetch. Once it completes, the fetched byte is readable at both addr 3/4 and addr 5.
- R7: Reading the data latch (addr 5) never starts a buffer access, never raises `busy` and never lowers `rdy`.
- R8: A completed access through addr 4 advances the pointer by one, wrapping from FFFFFh to 00000h. An access through addr 3 leaves the pointer unchanged.
- R9: `busy` is 1 from the clock edge that accepts a trigger until completion. `mem_req` is only high while `busy` is high. `mem_addr` equals the pointer at the trigger and stays stable for the whole access.
- R10: While `busy` is 1, pointer writes and new access triggers are ignored.
- R11: `mem_req` stays high until `mem_gnt`. A write carries `mem_we`=1 and the data byte. A read completes only after `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| no_wait_mode | input | 1 | 1 = non-waitable host bus, 0 = waitable |
| cs | input | 1 | Host chip select |
| rd_stb | input | 1 | Host read strobe (level) |
| wr_stb | input | 1 | Host write strobe (level) |
| addr | input | RAW (3) | Host register address |
| wdata | input | DW (8) | Host write data |
| rdata | output | DW (8) | Host read data for `addr` |
| rdy | output | 1 | Host ready / wait output |
| busy | output | 1 | Buffer access not ready |
| mem_req | output | 1 | Buffer access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW (20) | Buffer byte address |
| mem_wdata | output | DW (8) | Buffer write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW (8) | Read data |

## Verification
The assertions assume the memory side follows the handshake:

- `mem_gnt` is raised only while `mem_req` is high.
- `mem_rvalid` comes only after a read grant.

They also assume the host does not raise both strobes in the same cycle, and leaves at least one idle cycle between strobes. The stimulus keeps to this by driving the memory from a bench responder with a random or forced latency. Host cycles come only from tasks that drive one strobe at a time and drop it before the next cycle. The one deliberate protocol break is a waitable read abandoned after one cycle. Its purpose is to observe `rdy` with `cs` low during a live access.

// File: rtl/hbuf_pkg.sv
package hbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_REQ    = 2'd1,
        ST_RDWAIT = 2'd2,
        ST_DONE   = 2'd3
    } hb_state_t;
endpackage

// File: rtl/hbuf_strobe.sv
// Turns host strobe levels into single-cycle access events. The edge used
// depends on the bus mode: leading edge when waitable, trailing when not.
module hbuf_strobe #(
    parameter int DW  = 8,
    parameter int RAW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           no_wait_mode,
    input  logic           cs,
    input  logic           rd_stb,
    input  logic           wr_stb,
    input  logic [RAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic           rd_evt,
    output logic           wr_evt,
    output logic [RAW-1:0] evt_addr,
    output logic [DW-1:0]  evt_wdata
);
    logic           rd_act, wr_act, rd_q, wr_q;
    logic [RAW-1:0] addr_q;
    logic [DW-1:0]  wdata_q;

    assign rd_act = cs && rd_stb;
    assign wr_act = cs && wr_stb;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            rd_q <= rd_act;
            wr_q <= wr_act;
            if (rd_act || wr_act) addr_q  <= addr;
            if (wr_act)           wdata_q <= wdata;
        end
    end

    always_comb begin
        if (no_wait_mode) begin
            rd_evt    = rd_q && !rd_act;
            wr_evt    = wr_q && !wr_act;
            evt_addr  = addr_q;
            evt_wdata = wdata_q;
        end else begin
            rd_evt    = rd_act && !rd_q;
            wr_evt    = wr_act && !wr_q;
            evt_addr  = addr;
            evt_wdata = wdata;
        end
    end
endmodule

// File: rtl/hbuf_ptr.sv
// Buffer address pointer: byte-wise loads and a wrapping +1 step.
module hbuf_ptr #(
    parameter int AW = 20,
    parameter int DW = 8,
    parameter int SW = 3,
    localparam int NB = (AW + DW - 1) / DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [DW-1:0] wr_byte,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    logic [NB*DW-1:0] ext;
    logic [AW-1:0]    ptr_nxt;

    always_comb begin
        ext = '0;
        ext[AW-1:0] = ptr;
        for (int i = 0; i < NB; i++) begin
            if (wr_en && (wr_sel == SW'(i))) ext[i*DW +: DW] = wr_byte;
        end
        if (inc) ext = ext + 1'b1;
        ptr_nxt = ext[AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= ptr_nxt;
    end

    // R8: all-ones pointer steps to zero
    assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && (&ptr)) |=> (ptr == '0));
endmodule

// File: rtl/hbuf_fsm.sv
// Access sequencer: request/grant/read-data handshake to the buffer memory.
module hbuf_fsm #(
    parameter int AW = 20,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_we,
    input  logic          start_auto,
    input  logic [DW-1:0] start_wdata,
    input  logic [AW-1:0] ptr,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          busy,
    output logic          done,
    output logic          done_auto,
    output logic          rd_cap
);
    import hbuf_pkg::*;

    hb_state_t state, state_nxt;
    logic      auto_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
            auto_q    <= 1'b0;
        end else if (state == ST_IDLE && start) begin
            mem_we    <= start_we;
            mem_addr  <= ptr;
            mem_wdata <= start_wdata;
            auto_q    <= start_auto;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (start) state_nxt = ST_REQ;
            ST_REQ:    if (mem_gnt) state_nxt = mem_we ? ST_DONE : ST_RDWAIT;
            ST_RDWAIT: if (mem_rvalid) state_nxt = ST_DONE;
            ST_DONE:   state_nxt = ST_IDLE;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        busy      = 1'b1;
        done      = 1'b0;
        done_auto = 1'b0;
        rd_cap    = 1'b0;
        unique case (state)
            ST_IDLE:   busy = 1'b0;
            ST_REQ:    mem_req = 1'b1;
            ST_RDWAIT: rd_cap = mem_rvalid;
            ST_DONE: begin
                done      = 1'b1;
                done_auto = auto_q;
            end
            default:   busy = 1'b0;
        endcase
    end

    // R9: accepted trigger raises the request on the next cycle
    assert_start_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> mem_req);
    // R9: no request outside an access
    assert_req_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);
    // R9: address held for the whole access
    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));
    // R11: request held until granted
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> mem_req);
endmodule

// File: rtl/hbuf_port.sv
// Host buffer access port top: register window, ready logic, data latch.
module hbuf_port #(
    parameter int AW  = 20,
    parameter int DW  = 8,
    localparam int NB  = (AW + DW - 1) / DW,
    localparam int RAW = $clog2(NB + 3)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           no_wait_mode,
    input  logic           cs,
    input  logic           rd_stb,
    input  logic           wr_stb,
    input  logic [RAW-1:0] addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           rdy,
    output logic           busy,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [DW-1:0]  mem_wdata,
    input  logic           mem_gnt,
    input  logic           mem_rvalid,
    input  logic [DW-1:0]  mem_rdata
);
    localparam logic [RAW-1:0] A_ACC   = RAW'(NB);
    localparam logic [RAW-1:0] A_AUTO  = RAW'(NB + 1);
    localparam logic [RAW-1:0] A_LATCH = RAW'(NB + 2);

    logic           rd_evt, wr_evt;
    logic [RAW-1:0] evt_addr;
    logic [DW-1:0]  evt_wdata;
    logic           evt_acc, start, ptr_wr;
    logic           done, done_auto, rd_cap, served, wait_hold;
    logic [AW-1:0]  ptr;
    logic [DW-1:0]  acc_data, latch_data;
    logic [NB*DW-1:0] ptr_ext;

    hbuf_strobe #(.DW(DW), .RAW(RAW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .no_wait_mode(no_wait_mode),
        .cs(cs), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .evt_addr(evt_addr), .evt_wdata(evt_wdata)
    );

    assign evt_acc = (evt_addr == A_ACC) || (evt_addr == A_AUTO);
    assign start   = !busy && evt_acc && (rd_evt || wr_evt);
    assign ptr_wr  = !busy && wr_evt && (evt_addr < RAW'(NB));

    hbuf_ptr #(.AW(AW), .DW(DW), .SW(RAW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_sel(evt_addr),
        .wr_byte(evt_wdata), .inc(done_auto), .ptr(ptr)
    );

    hbuf_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .start_we(wr_evt),
        .start_auto(evt_addr == A_AUTO), .start_wdata(evt_wdata), .ptr(ptr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .done_auto(done_auto), .rd_cap(rd_cap)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_data   <= '0;
            latch_data <= '0;
            served     <= 1'b0;
        end else begin
            if (start && wr_evt) acc_data <= evt_wdata;
            else if (rd_cap)     acc_data <= mem_rdata;
            if (rd_cap) latch_data <= mem_rdata;
            if (!(rd_stb || wr_stb)) served <= 1'b0;
            else if (done)           served <= 1'b1;
        end
    end

    assign wait_hold = cs && (busy || (((addr == A_ACC) || (addr == A_AUTO))
                                       && (rd_stb || wr_stb) && !served));
    assign rdy = no_wait_mode ? !busy : !wait_hold;

    always_comb begin
        ptr_ext = '0;
        ptr_ext[AW-1:0] = ptr;
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == RAW'(i)) rdata = ptr_ext[i*DW +: DW];
        end
        if (addr == A_ACC || addr == A_AUTO) rdata = acc_data;
        if (addr == A_LATCH)                 rdata = latch_data;
    end

    // R4: deselected waitable bus is never held
    assert_rdy_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_wait_mode && !cs) |-> rdy);
    // R5: non-waitable ready mirrors the not-ready flag
    assert_rdy_poll_R5: assert property (@(posedge clk) disable iff (!rst_n)
        no_wait_mode |-> (rdy == !busy));
    // R10: pointer frozen inside an access
    assert_ptr_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ptr));
    // R7: a latch read while idle starts nothing
    assert_latch_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_evt && evt_addr == A_LATCH) |=> !busy);
endmodule

// File: tb/tb_hbuf_port.sv
`timescale 1ns/1ps
module tb_hbuf_port;
    localparam int A_ACC = 3, A_AUTO = 4, A_LATCH = 5;

    logic clk = 0, rst_n = 0, no_wait_mode = 0;
    logic cs = 0, rd_stb = 0, wr_stb = 0;
    logic [2:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic rdy, busy, mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata = 0;
    logic mem_gnt = 0, mem_rvalid = 0;

    int errors = 0, checks = 0, lat_fix = 0;
    bit finished = 0;
    logic [7:0] bmem [int unsigned];
    logic [19:0] mp;
    logic [7:0] exp_acc = 0;
    logic saw_low;

    always #2.5 clk = ~clk;

    hbuf_port dut (
        .clk(clk), .rst_n(rst_n), .no_wait_mode(no_wait_mode), .cs(cs),
        .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdy(rdy), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] mget(logic [19:0] a);
        return bmem.exists(int'(a)) ? bmem[int'(a)] : 8'h00;
    endfunction

    function automatic logic [7:0] pbyte(logic [19:0] p, int i);
        logic [23:0] e = {4'h0, p};
        return e[i*8 +: 8];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // memory responder
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                int lat;
                logic [19:0] a;
                logic we;
                logic [7:0] d;
                lat = (lat_fix != 0) ? lat_fix : int'($urandom_range(0, 3));
                repeat (lat) @(negedge clk);
                a = mem_addr; we = mem_we; d = mem_wdata;
                mem_gnt = 1;
                @(negedge clk);
                mem_gnt = 0;
                if (we) bmem[int'(a)] = d;
                else begin
                    lat = (lat_fix != 0) ? lat_fix : int'($urandom_range(0, 3));
                    repeat (lat) @(negedge clk);
                    mem_rdata = mget(a);
                    mem_rvalid = 1;
                    @(negedge clk);
                    mem_rvalid = 0;
                end
            end
        end
    end

    // waitable host cycles
    task automatic w_write(int a, logic [7:0] d);
        @(negedge clk); cs = 1; wr_stb = 1; addr = 3'(a); wdata = d;
        @(negedge clk); saw_low = !rdy;
        while (!rdy) @(negedge clk);
        cs = 0; wr_stb = 0;
        @(negedge clk);
    endtask

    task automatic w_read(int a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd_stb = 1; addr = 3'(a);
        @(negedge clk); saw_low = !rdy;
        while (!rdy) @(negedge clk);
        d = rdata; cs = 0; rd_stb = 0;
        @(negedge clk);
    endtask

    // non-waitable host cycles (one-cycle strobe)
    task automatic n_write(int a, logic [7:0] d);
        @(negedge clk); cs = 1; wr_stb = 1; addr = 3'(a); wdata = d;
        @(negedge clk); cs = 0; wr_stb = 0;
    endtask

    task automatic n_read(int a, output logic [7:0] d);
        @(negedge clk); cs = 1; rd_stb = 1; addr = 3'(a);
        @(negedge clk); d = rdata; cs = 0; rd_stb = 0;
    endtask

    task automatic n_idle();
        @(negedge clk);
        while (!rdy) @(negedge clk);
    endtask

    task automatic w_setptr(logic [19:0] p);
        for (int i = 0; i < 3; i++) w_write(i, pbyte(p, i));
    endtask

    task automatic w_chkptr(string req, logic [19:0] p);
        logic [7:0] d;
        for (int i = 0; i < 3; i++) begin
            w_read(i, d);
            chk(req, d, pbyte(p, i));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog R1-all act=timeout exp=done");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d, v;
        logic [19:0] q;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdy", rdy, 1); chk("R1 busy", busy, 0); chk("R1 mem_req", mem_req, 0);
        w_chkptr("R1 ptr", 20'h0);
        w_read(A_LATCH, d); chk("R1 latch", d, 0);

        // R2 pointer bytes
        mp = 20'h3A5C7;
        w_setptr(mp); w_chkptr("R2 ptr", mp);
        w_write(2, 8'hF9); mp[19:16] = 4'h9;
        w_chkptr("R2 byte2 mask", mp);

        // R3/R8 waitable writes through auto register
        q = mp;
        for (int i = 0; i < 4; i++) begin
            v = 8'(8'h10 + i * 7);
            w_write(A_AUTO, v); exp_acc = v;
            chk("R3 rdy held on write", saw_low, 1);
            chk("R3 stored", mget(q + 20'(i)), v);
        end
        mp = q + 20'd4;
        w_chkptr("R8 auto step", mp);

        // R3/R8 plain reads leave pointer
        w_setptr(q); mp = q;
        for (int i = 0; i < 2; i++) begin
            w_read(A_ACC, d); exp_acc = d;
            chk("R3 plain read", d, 8'h10);
            chk("R3 rdy held on read", saw_low, 1);
        end
        w_chkptr("R8 plain no step", q);
        for (int i = 0; i < 4; i++) begin
            w_read(A_AUTO, d); exp_acc = d;
            chk("R3 auto read", d, 8'(8'h10 + i * 7));
        end

        // R8 wrap
        mp = 20'hFFFFF; w_setptr(mp);
        w_write(A_AUTO, 8'hC3); exp_acc = 8'hC3;
        chk("R8 write at top", mget(20'hFFFFF), 8'hC3);
        w_chkptr("R8 wrap", 20'h0);

        // R4 deselected during a live waitable access
        lat_fix = 4;
        @(negedge clk); cs = 1; rd_stb = 1; addr = 3'(A_ACC);
        @(negedge clk); chk("R3 rdy low at lead edge", rdy, 0); cs = 0; rd_stb = 0;
        @(negedge clk); chk("R4 busy live", busy, 1); chk("R4 rdy with cs low", rdy, 1);
        while (busy) @(negedge clk);
        exp_acc = mget(20'h0);
        lat_fix = 0;

        // random waitable mix
        mp = 20'h0; w_setptr(mp);
        for (int n = 0; n < 40; n++) begin
            int op = int'($urandom_range(0, 3));
            v = 8'($urandom);
            case (op)
                0: begin
                    int b = int'($urandom_range(0, 2));
                    w_write(b, v);
                    if (b == 2) mp[19:16] = v[3:0];
                    else mp[b*8 +: 8] = v;
                end
                1: begin
                    w_write(A_AUTO, v); exp_acc = v;
                    chk("R3 rnd write", mget(mp), v);
                    mp = mp + 1;
                end
                2: begin
                    w_read(A_AUTO, d); chk("R3 rnd auto read", d, mget(mp));
                    exp_acc = d; mp = mp + 1;
                end
                default: begin
                    w_read(A_ACC, d); chk("R3 rnd plain read", d, mget(mp));
                    exp_acc = d;
                end
            endcase
        end
        w_chkptr("R8 rnd ptr", mp);

        // non-waitable mode
        no_wait_mode = 1;
        q = 20'h01230;
        for (int i = 0; i < 3; i++) n_write(i, pbyte(q, i));
        n_write(A_AUTO, 8'h5E);
        @(negedge clk);
        chk("R5 busy after trailing edge", busy, 1);
        chk("R5 rdy polls with cs low", rdy, 0);
        n_idle();
        exp_acc = 8'h5E;
        chk("R5 stored", mget(q), 8'h5E);
        n_read(0, d); chk("R8 nw auto step", d, 8'h31);

        // R6 discard read then collect
        for (int i = 0; i < 3; i++) n_write(i, pbyte(q, i));
        bmem[int'(q + 20'd1)] = 8'hA7;
        n_read(A_AUTO, d); chk("R6 discard value", d, exp_acc);
        @(negedge clk);
        chk("R9 busy", busy, 1); chk("R9 mem_addr", mem_addr, q);
        n_idle();
        n_read(A_LATCH, d); chk("R6 latch", d, 8'h5E);
        @(negedge clk);
        chk("R7 latch read busy", busy, 0); chk("R7 latch read rdy", rdy, 1);
        n_read(A_AUTO, d); chk("R6 access reg", d, 8'h5E);
        @(negedge clk); chk("R7 access reg starts", busy, 1);
        n_idle();
        n_read(A_LATCH, d); chk("R6 second fetch", d, 8'hA7);

        // R10 writes during a pending access
        lat_fix = 6;
        for (int i = 0; i < 3; i++) n_write(i, pbyte(q, i));
        v = mget(q);
        n_read(A_ACC, d);
        n_write(0, 8'hAA);
        n_write(A_ACC, 8'h55);
        n_read(A_AUTO, d);
        n_idle();
        lat_fix = 0;
        n_read(0, d); chk("R10 ptr ignored", d, pbyte(q, 0));
        n_read(1, d); chk("R10 ptr ignored hi", d, pbyte(q, 1));
        chk("R10 write ignored", mget(q), v);
        n_read(A_LATCH, d); chk("R10 latch", d, v);
        @(negedge clk); chk("R11 req idle", mem_req, 0);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule